// File: doc/BRIEF.md
# Flash Data-Polling Completion Controller

This block sits on the host side of a byte-wide flash device. Once the last write of a program or erase command has gone out, the block receives a start pulse. With it come the target address, the byte that was written and a program/erase select. From then on it reads that address over a simple request/acknowledge read bus until the device reports completion, and then reports pass or fail.

Completion is judged on bit 7 of each read. On a program, bit 7 shows the inverse of the written bit while the operation runs. On an erase, bit 7 shows 0 while the operation runs. Bit 5 is a time-limit flag. Near the end of an operation the device can switch from status to real data between two adjacent reads. For this reason the block never trusts one read. It re-reads once after seeing the time-limit flag before it gives up. It also re-reads the whole byte after bit 7 matches, and only then declares pass.

For an erase, the caller must pick an address inside a sector that is being erased and is not protected. Sending the command sequence and deciding whether to retry belong to the caller.

Top module: `flash_poll_ctrl`

## Requirements
- R1: A start_i pulse while idle latches the address, the expected byte and the erase select, and rd_req_o rises on the next cycle. A start_i while busy_o is high is ignored: the address being read does not change and no extra result is produced.
- R2: rd_req_o stays high with rd_addr_o held constant until a cycle with rd_ack_i high. rd_data_i is sampled in that same cycle. Every read goes to the latched address.
- R3: In program mode (erase_i = 0), a poll read matches when its bit 7 equals bit 7 of the expected byte.
- R4: In erase mode (erase_i = 1), a poll read matches when its bit 7 is 1, whatever the expected byte holds.
- R5: After a matching poll read, exactly one verify read follows. The result is pass if all eight bits equal the expected byte (program) or 8'hFF (erase), and fail otherwise.
- R6: A non-matching poll read with bit 5 set triggers exactly one more poll read, even when the poll limit is reached. If that read matches, the verify step follows. If it does not match, the result is fail.
- R7: If MAX_POLLS poll reads have completed with no match and no re-read pending from R6, the result is fail and polling stops.
- R8: Results appear as a one-cycle done_o pulse with exactly one of pass_o/fail_o high. busy_o is high from the cycle after the accepted start until the cycle before done_o. After reset, busy_o, done_o, pass_o, fail_o and rd_req_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (one-cycle pulse) |
| addr_i | input | AW | Address to poll |
| exp_data_i | input | 8 | Byte that was programmed |
| erase_i | input | 1 | 1 = erase operation, 0 = program operation |
| rd_req_o | output | 1 | Read request to flash |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read data valid this cycle |
| rd_data_i | input | 8 | Read data |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | Result valid pulse |
| pass_o | output | 1 | Operation completed correctly |
| fail_o | output | 1 | Operation failed or timed out |

## Verification
The bench targets status-then-data switching. In that case bit 7 matches while the low bits are still garbage. A design that passes on the first match, with no verify read, would report pass on a bad byte. The bench also sends a time-limit flag immediately followed by a matching read. A design that fails on the flag right away would report a false failure. The flag is also sent on the last allowed poll, where a design that ranks the watchdog ahead of the re-read would stop early. An exact count of reads catches off-by-one errors at the poll limit and extra or missing verify reads. Erase runs with unrelated expected bytes catch a design that compares against the written data instead of 1s.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned DONE_BIT  = 7;
  localparam int unsigned TMO_BIT   = 5;
  localparam logic [DW-1:0] ERASED  = '1;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_POLL   = 2'd1,
    S_VERIFY = 2'd2,
    S_DONE   = 2'd3
  } poll_state_e;
endpackage

// File: rtl/poll_decode.sv
module poll_decode
  import flash_poll_pkg::*;
(
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] exp_i,
  input  logic          erase_i,
  output logic          hit_o,
  output logic          tmo_o,
  output logic          full_ok_o
);
  logic [DW-1:0] ref_byte;

  always_comb begin
    ref_byte  = erase_i ? ERASED : exp_i;
    hit_o     = (data_i[DONE_BIT] == ref_byte[DONE_BIT]);
    tmo_o     = data_i[TMO_BIT];
    full_ok_o = (data_i == ref_byte);
  end
endmodule

// File: rtl/poll_counter.sv
module poll_counter #(
  parameter int unsigned MAX_POLLS = 64,
  localparam int unsigned CW = $clog2(MAX_POLLS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (clr_i)                                cnt_q <= '0;
    else if (inc_i && cnt_q != CW'(MAX_POLLS))     cnt_q <= cnt_q + 1'b1;
  end

  // true when the read being counted now is the final one allowed
  assign last_o = (cnt_q >= CW'(MAX_POLLS - 1));

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_POLLS));
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int unsigned AW        = 18,
  parameter int unsigned MAX_POLLS = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic          erase_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o
);
  poll_state_e   st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic          erase_q, recheck_q, recheck_d, res_q, res_d;
  logic          hit, tmo, full_ok, last;
  logic          accept, poll_ack;

  assign accept   = (st_q == S_IDLE) && start_i;
  assign poll_ack = (st_q == S_POLL) && rd_ack_i;

  poll_decode u_dec (
    .data_i   (rd_data_i),
    .exp_i    (exp_q),
    .erase_i  (erase_q),
    .hit_o    (hit),
    .tmo_o    (tmo),
    .full_ok_o(full_ok)
  );

  poll_counter #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .inc_i (poll_ack),
    .last_o(last)
  );

  always_comb begin
    st_d      = st_q;
    recheck_d = recheck_q;
    res_d     = res_q;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d      = S_POLL;
        recheck_d = 1'b0;
      end
      S_POLL: if (rd_ack_i) begin
        if (hit) begin
          st_d = S_VERIFY;
        end else if (recheck_q) begin
          st_d  = S_DONE;
          res_d = 1'b0;
        end else if (tmo) begin
          recheck_d = 1'b1;          // one more read before giving up
        end else if (last) begin
          st_d  = S_DONE;
          res_d = 1'b0;
        end
      end
      S_VERIFY: if (rd_ack_i) begin
        st_d  = S_DONE;
        res_d = full_ok;
      end
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      addr_q    <= '0;
      exp_q     <= '0;
      erase_q   <= 1'b0;
      recheck_q <= 1'b0;
      res_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      recheck_q <= recheck_d;
      res_q     <= res_d;
      if (accept) begin
        addr_q  <= addr_i;
        exp_q   <= exp_data_i;
        erase_q <= erase_i;
      end
    end
  end

  assign rd_req_o  = (st_q == S_POLL) || (st_q == S_VERIFY);
  assign rd_addr_o = addr_q;
  assign busy_o    = rd_req_o;
  assign done_o    = (st_q == S_DONE);
  assign pass_o    = done_o && res_q;
  assign fail_o    = done_o && !res_q;

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));
  p_start_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(rd_addr_o));
  p_start_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !done_o && start_i |=> rd_req_o);
  p_done_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({pass_o, fail_o}));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  p_result_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |-> done_o);
  p_verify_after_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_POLL) && rd_ack_i && hit |=> rd_req_o && !done_o);
endmodule

// File: tb/flash_poll_ctrl_test.sv
`timescale 1ns/1ps
module flash_poll_ctrl_test;
  localparam int AW  = 12;
  localparam int MAX = 12;

  logic clk = 0, rst_n = 0;
  logic start = 0, erase = 0, ack = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] exp_b = '0, rdata = '0;
  logic req, busy, done, pass, fail;
  logic [AW-1:0] raddr;

  int tests = 0, fails = 0;
  logic [7:0] arr [32];
  int idx = 0, wt = 0;
  logic [AW-1:0] cur_addr = '0;
  bit addr_bad = 0;

  always #2.5 clk = ~clk;

  flash_poll_ctrl #(.AW(AW), .MAX_POLLS(MAX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .exp_data_i(exp_b), .erase_i(erase), .rd_req_o(req), .rd_addr_o(raddr),
    .rd_ack_i(ack), .rd_data_i(rdata), .busy_o(busy), .done_o(done),
    .pass_o(pass), .fail_o(fail));

  function automatic logic [7:0] resp(int i);
    return arr[(i > 31) ? 31 : i];
  endfunction

  // flash model: answers requests after a random 0..2 cycle latency
  always @(negedge clk) begin
    ack = 0;
    rdata = 8'($urandom);
    if (req && !ack_prev()) begin
      if (wt == 0) begin
        ack = 1;
        rdata = resp(idx);
        idx++;
        if (raddr !== cur_addr) addr_bad = 1;
        wt = $urandom % 3;
      end else wt--;
    end
  end
  logic ack_q = 0;
  always @(posedge clk) ack_q <= ack;
  function automatic bit ack_prev(); return ack_q; endfunction

  function automatic void ref_model(bit er, logic [7:0] e, output bit ok, output int n);
    logic [7:0] r, d;
    bit rchk;
    r = er ? 8'hFF : e;
    rchk = 0; n = 0; ok = 0;
    forever begin
      d = resp(n); n++;
      if (d[7] == r[7]) begin
        d = resp(n); n++;
        ok = (d == r);
        return;
      end else if (rchk) return;
      else if (d[5]) rchk = 1;
      else if (n >= MAX) return;
    end
  endfunction

  task automatic check(bit c, string req_s, string msg, int act, int expv);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req_s, msg, act, expv);
    end
  endtask

  task automatic run(bit er, logic [7:0] e, string tag, bit mid_start);
    bit ok; int n; int cyc; bit got_pass;
    ref_model(er, e, ok, n);
    idx = 0; wt = $urandom % 3; addr_bad = 0;
    @(negedge clk);
    addr = AW'($urandom); cur_addr = addr; exp_b = e; erase = er; start = 1;
    @(negedge clk);
    start = 0;
    check(req === 1'b1, "R1", {tag, " req after start"}, int'(req), 1);
    if (mid_start) begin
      addr = ~cur_addr; start = 1;
      @(negedge clk); start = 0;
    end
    cyc = 0;
    while (done !== 1'b1 && cyc < 2000) begin @(negedge clk); cyc++; end
    check(done === 1'b1, tag, "done seen", int'(done), 1);
    got_pass = pass;
    check(got_pass == ok && fail == !ok, tag, "pass result", int'(got_pass), int'(ok));
    check(idx == n, tag, "read count", idx, n);
    check(!addr_bad, "R2", {tag, " read address"}, int'(addr_bad), 0);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R8", {tag, " done one cycle"}, int'(done), 0);
    if (mid_start) check(req === 1'b0, "R1", "busy start ignored", int'(req), 0);
  endtask

  function automatic void fill_status(bit er, logic [7:0] e);
    for (int i = 0; i < 32; i++) begin
      arr[i] = 8'($urandom);
      arr[i][7] = er ? 1'b0 : ~e[7];
      arr[i][5] = 1'b0;
    end
  endfunction

  initial begin
    int t0;
    void'($urandom(32'h5eed_1234));
    #1;
    check(busy === 0 && done === 0 && pass === 0 && fail === 0 && req === 0,
          "R8", "reset outputs", int'(busy), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R3: program, 3 busy reads then good data
    fill_status(0, 8'hA5); for (int i = 3; i < 32; i++) arr[i] = 8'hA5;
    run(0, 8'hA5, "R3", 0);
    // R3: program with bit7 = 0
    fill_status(0, 8'h3C); for (int i = 5; i < 32; i++) arr[i] = 8'h3C;
    run(0, 8'h3C, "R3", 0);
    // R5: bit7 matches first with garbage low bits, then real data
    fill_status(0, 8'hC3); arr[2] = 8'hC0; for (int i = 3; i < 32; i++) arr[i] = 8'hC3;
    run(0, 8'hC3, "R5", 0);
    // R5: verify read wrong -> fail
    fill_status(0, 8'h81); arr[1] = 8'h81; arr[2] = 8'h80;
    run(0, 8'h81, "R5", 0);
    // R4: erase, expected byte irrelevant
    fill_status(1, 8'h00); for (int i = 4; i < 32; i++) arr[i] = 8'hFF;
    run(1, 8'h00, "R4", 0);
    // R4/R5: erase verify against FF, not expected
    fill_status(1, 8'h80); arr[1] = 8'h80; arr[2] = 8'h80;
    run(1, 8'h80, "R4", 0);
    // R6: timeout flag then match
    fill_status(0, 8'h5A); arr[2][5] = 1; arr[3] = 8'h5A; arr[4] = 8'h5A;
    run(0, 8'h5A, "R6", 0);
    // R6: timeout flag then still busy -> fail
    fill_status(0, 8'h5A); arr[1][5] = 1;
    run(0, 8'h5A, "R6", 0);
    // R6: timeout flag on the last allowed poll still re-reads
    fill_status(0, 8'h11); arr[MAX-1][5] = 1; arr[MAX] = 8'h11; arr[MAX+1] = 8'h11;
    run(0, 8'h11, "R6", 0);
    // R7: never completes -> watchdog
    fill_status(1, 8'h00);
    run(1, 8'h00, "R7", 0);
    // R7: completes on the last allowed poll
    fill_status(0, 8'h77); arr[MAX-1] = 8'h77; arr[MAX] = 8'h77;
    run(0, 8'h77, "R7", 0);
    // R1: start while busy ignored
    fill_status(0, 8'h42); for (int i = 6; i < 32; i++) arr[i] = 8'h42;
    run(0, 8'h42, "R1", 1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      bit er; logic [7:0] e; int b;
      er = 1'($urandom); e = 8'($urandom); b = $urandom % (MAX + 4);
      fill_status(er, e);
      for (int i = 0; i < 32; i++) if ($urandom % 6 == 0) arr[i][5] = 1;
      for (int i = b; i < 32; i++) arr[i] = er ? 8'hFF : e;
      if ($urandom % 4 == 0 && b < 31) arr[b][0] = ~arr[b][0];
      run(er, e, "R5", 0);
    end
    t0 = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #900000;
    fails++; tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule